// File: doc/BRIEF.md
# Shared External Interrupt Controller

This block collects a parameterized set of external interrupt lines (32 by default) and delivers them to several processor contexts. Each input first passes through a two-flop synchronizer. It is then conditioned by its own polarity, trigger-mode and dual-edge settings into a pending state. The pending state is gated by an enable mask and routed to one interrupt pin, the NMI line or a special line of every context selected in its target bitmap.

Software sets everything up through a plain 32-bit word-addressed read/write port. Masks change only through write-one-to-set and write-one-to-clear words. Latched edge state can be forced on or off by writing a source number and a command bit to a single edge-control word. Per-source configuration bits are banked: source i sits in bank word i/32, bit i%32.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, polarity, trigger, dual-edge, mask, routing and target bitmaps read 0, and all interrupt, NMI and special outputs are 0.
- R2: With the trigger bit 0 (level mode), pending follows the synchronized input: a polarity bit of 1 makes a high input pending, and a polarity bit of 0 makes a low input pending.
- R3: With the trigger bit 1 (edge mode), a rising input edge (polarity 1) or a falling edge (polarity 0) sets a latched edge flag. Pending then stays 1 until the flag is cleared, whatever the input does.
- R4: With trigger and dual-edge bits both 1, both input transitions set the edge flag.
- R5: Writing 1s to the set-mask word (0x018+bank) enables those sources, and writing 1s to the clear-mask word (0x020+bank) disables them. Zero bits, or a whole zero word, change nothing. The mask status word (0x028+bank) reads 1 per enabled source.
- R6: A write to the edge-control word (0x038) carries a source number in bits 7:0. Bit 31 = 1 sets that source's edge flag and bit 31 = 0 clears it. A number of NUM_SRC or more is ignored.
- R7: The routing word of source i (0x040+i) has bit 31 = deliver to interrupt pin, bit 30 = deliver to NMI, bit 29 = deliver to the special line, and bits 5:0 = pin number. Only these bits are stored and read back. A pin number of NUM_PIN or more drives no line.
- R8: The target bitmap of source i selects context n through bit n%32 of word 0x100 + 4*i + n/32. A source reaches only the contexts whose bits are set.
- R9: Interrupt output bit c*NUM_PIN+p, and NMI or special output bit c, is 1 one clock after at least one source is pending, enabled, routed to that line and targeted at context c. Otherwise it is 0.
- R10: Polarity, trigger and dual-edge live at bank words 0x000, 0x008 and 0x010 (+bank) and read back as written. The pending status is at 0x030+bank. The set-mask, clear-mask and edge-control words read 0.
- R11: A level input change shows in pending after exactly two rising clock edges, and on the outputs after a third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | External interrupt lines, asynchronous |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | NUM_CTX*NUM_PIN | Interrupt pins, context c pin p at bit c*NUM_PIN+p |
| nmi_o | output | NUM_CTX | NMI line per context |
| spec_o | output | NUM_CTX | Special line per context |

## Verification
The assertions take it that the bus carries at most one write per cycle, so set-mask and clear-mask never collide. They also take it that an edge-control write names a single source, which leaves the flag commands one-hot. The mask assertions watch bank 0 only, which covers the default 32 sources. Input lines are asynchronous to the design, but the bench changes them and the bus only at falling clock edges. It holds idle lines high, so under the reset polarity (active-low level) nothing is pending until a test pulls a line low.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int ADDR_W     = 10;
  localparam int PIN_W      = 6;
  localparam int CTX_STRIDE = 4;
  localparam int IDX_W      = 8;

  localparam logic [ADDR_W-1:0] A_POL   = 10'h000;
  localparam logic [ADDR_W-1:0] A_TRIG  = 10'h008;
  localparam logic [ADDR_W-1:0] A_DUAL  = 10'h010;
  localparam logic [ADDR_W-1:0] A_MSET  = 10'h018;
  localparam logic [ADDR_W-1:0] A_MCLR  = 10'h020;
  localparam logic [ADDR_W-1:0] A_MASK  = 10'h028;
  localparam logic [ADDR_W-1:0] A_PEND  = 10'h030;
  localparam logic [ADDR_W-1:0] A_EDGE  = 10'h038;
  localparam logic [ADDR_W-1:0] A_ROUTE = 10'h040;
  localparam logic [ADDR_W-1:0] A_CTX   = 10'h100;

  typedef struct packed {
    logic             pin_en;
    logic             nmi_en;
    logic             spec_en;
    logic [PIN_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/eic_src_cell.sv
module eic_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, prev_q, flag_q;
  logic flag_d, rise, fall, ev;

  // next state
  always_comb begin
    rise   = s2_q & ~prev_q;
    fall   = ~s2_q & prev_q;
    ev     = trig_i & (dual_i ? (rise | fall) : (pol_i ? rise : fall));
    flag_d = flag_q;
    if (sw_clr_i) flag_d = 1'b0;
    if (sw_set_i || ev) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      flag_q <= flag_d;
    end
  end

  assign pend_o = trig_i ? flag_q : (s2_q ~^ pol_i);

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clr_i) |=> flag_q);
  assert_edge_catch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !dual_i && (pol_i ? rise : fall)) |=> flag_q);
  assert_dual_catch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && dual_i && (s2_q != prev_q)) |=> flag_q);
  assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_i && !sw_set_i && !trig_i) |=> !flag_q);
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  input  logic [NUM_SRC-1:0]          pend_i,
  output logic [NUM_SRC-1:0]          pol_o,
  output logic [NUM_SRC-1:0]          trig_o,
  output logic [NUM_SRC-1:0]          dual_o,
  output logic [NUM_SRC-1:0]          mask_o,
  output logic [NUM_SRC-1:0]          edge_set_o,
  output logic [NUM_SRC-1:0]          edge_clr_o,
  output route_t [NUM_SRC-1:0]        route_o,
  output logic [NUM_SRC*NUM_CTX-1:0]  ctx_o
);
  localparam int NB   = (NUM_SRC + 31) / 32;
  localparam int NPAD = NB * 32;
  localparam logic [NPAD-1:0] VALID = {NPAD{1'b1}} >> (NPAD - NUM_SRC);

  logic [NPAD-1:0] pol_q, trig_q, dual_q, mask_q;
  logic [NPAD-1:0] pol_d, trig_d, dual_d, mask_d;
  route_t [NUM_SRC-1:0] route_q, route_d;
  logic [NUM_SRC*NUM_CTX-1:0] ctx_q, ctx_d;
  logic [NPAD-1:0] pend_pad;

  assign pend_pad = NPAD'(pend_i);

  // next state for every stored field
  always_comb begin
    pol_d   = pol_q;
    trig_d  = trig_q;
    dual_d  = dual_q;
    mask_d  = mask_q;
    route_d = route_q;
    ctx_d   = ctx_q;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == A_POL  + ADDR_W'(b)) pol_d[b*32 +: 32]  = bus_wdata;
      if (bus_addr == A_TRIG + ADDR_W'(b)) trig_d[b*32 +: 32] = bus_wdata;
      if (bus_addr == A_DUAL + ADDR_W'(b)) dual_d[b*32 +: 32] = bus_wdata;
      if (bus_addr == A_MSET + ADDR_W'(b)) mask_d[b*32 +: 32] = mask_q[b*32 +: 32] | bus_wdata;
      if (bus_addr == A_MCLR + ADDR_W'(b)) mask_d[b*32 +: 32] = mask_q[b*32 +: 32] & ~bus_wdata;
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_addr == A_ROUTE + ADDR_W'(i))
        route_d[i] = '{pin_en: bus_wdata[31], nmi_en: bus_wdata[30],
                       spec_en: bus_wdata[29], pin: bus_wdata[PIN_W-1:0]};
      for (int c = 0; c < NUM_CTX; c++)
        if (bus_addr == A_CTX + ADDR_W'(i*CTX_STRIDE + c/32))
          ctx_d[i*NUM_CTX+c] = bus_wdata[c%32];
    end
    pol_d  = pol_d  & VALID;
    trig_d = trig_d & VALID;
    dual_d = dual_d & VALID;
    mask_d = mask_d & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
      ctx_q   <= '0;
    end else if (bus_we) begin
      pol_q   <= pol_d;
      trig_q  <= trig_d;
      dual_q  <= dual_d;
      mask_q  <= mask_d;
      route_q <= route_d;
      ctx_q   <= ctx_d;
    end
  end

  // edge-control decode: one source per write
  always_comb begin
    edge_set_o = '0;
    edge_clr_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_we && bus_addr == A_EDGE && bus_wdata[IDX_W-1:0] == IDX_W'(i)) begin
        edge_set_o[i] = bus_wdata[31];
        edge_clr_o[i] = ~bus_wdata[31];
      end
    end
  end

  // read mux; write-only and unmapped words return 0
  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == A_POL  + ADDR_W'(b)) bus_rdata = pol_q[b*32 +: 32];
      if (bus_addr == A_TRIG + ADDR_W'(b)) bus_rdata = trig_q[b*32 +: 32];
      if (bus_addr == A_DUAL + ADDR_W'(b)) bus_rdata = dual_q[b*32 +: 32];
      if (bus_addr == A_MASK + ADDR_W'(b)) bus_rdata = mask_q[b*32 +: 32];
      if (bus_addr == A_PEND + ADDR_W'(b)) bus_rdata = pend_pad[b*32 +: 32];
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (bus_addr == A_ROUTE + ADDR_W'(i))
        bus_rdata = {route_q[i].pin_en, route_q[i].nmi_en, route_q[i].spec_en,
                     {(29-PIN_W){1'b0}}, route_q[i].pin};
      for (int c = 0; c < NUM_CTX; c++)
        if (bus_addr == A_CTX + ADDR_W'(i*CTX_STRIDE + c/32))
          bus_rdata[c%32] = ctx_q[i*NUM_CTX+c];
    end
  end

  assign pol_o   = pol_q[NUM_SRC-1:0];
  assign trig_o  = trig_q[NUM_SRC-1:0];
  assign dual_o  = dual_q[NUM_SRC-1:0];
  assign mask_o  = mask_q[NUM_SRC-1:0];
  assign route_o = route_q;
  assign ctx_o   = ctx_q;

  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MSET) |=>
      ((mask_q[31:0] & $past(bus_wdata)) == ($past(bus_wdata) & VALID[31:0])));
  assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_MCLR) |=> ((mask_q[31:0] & $past(bus_wdata)) == 32'h0));
  assert_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == A_MSET || bus_addr == A_MCLR) && bus_wdata == 32'h0)
      |=> $stable(mask_q));
  assert_edge_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(edge_set_o | edge_clr_o));
endmodule

// File: rtl/eic_route.sv
module eic_route
  import eic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int NUM_PIN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          active_i,
  input  route_t [NUM_SRC-1:0]        route_i,
  input  logic [NUM_SRC*NUM_CTX-1:0]  ctx_i,
  output logic [NUM_CTX*NUM_PIN-1:0]  irq_o,
  output logic [NUM_CTX-1:0]          nmi_o,
  output logic [NUM_CTX-1:0]          spec_o
);
  logic [NUM_CTX*NUM_PIN-1:0] irq_d, irq_q;
  logic [NUM_CTX-1:0] nmi_d, nmi_q, spec_d, spec_q;
  logic [NUM_SRC-1:0] nmi_src;

  always_comb begin
    irq_d  = '0;
    nmi_d  = '0;
    spec_d = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      nmi_src[i] = active_i[i] & route_i[i].nmi_en;
      for (int c = 0; c < NUM_CTX; c++) begin
        if (active_i[i] && ctx_i[i*NUM_CTX+c]) begin
          if (route_i[i].nmi_en)  nmi_d[c]  = 1'b1;
          if (route_i[i].spec_en) spec_d[c] = 1'b1;
          for (int p = 0; p < NUM_PIN; p++)
            if (route_i[i].pin_en && route_i[i].pin == PIN_W'(p))
              irq_d[c*NUM_PIN+p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      nmi_q  <= '0;
      spec_q <= '0;
    end else begin
      irq_q  <= irq_d;
      nmi_q  <= nmi_d;
      spec_q <= spec_d;
    end
  end

  assign irq_o  = irq_q;
  assign nmi_o  = nmi_q;
  assign spec_o = spec_q;

  assert_irq_needs_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> $past(|active_i));
  assert_nmi_needs_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|nmi_q) |-> $past(|nmi_src));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i == '0) |=> (irq_q == '0 && nmi_q == '0 && spec_q == '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_CTX = 2,
  parameter int NUM_PIN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_i,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic [NUM_CTX*NUM_PIN-1:0]  irq_o,
  output logic [NUM_CTX-1:0]          nmi_o,
  output logic [NUM_CTX-1:0]          spec_o
);
  logic rst_a_q, rst_b_q, rst_s;
  logic [NUM_SRC-1:0] pol, trig, dual, mask, eset, eclr, pend, active;
  route_t [NUM_SRC-1:0] route;
  logic [NUM_SRC*NUM_CTX-1:0] ctx;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign rst_s = rst_b_q;

  eic_regs #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_regs (
    .clk(clk), .rst_n(rst_s), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend),
    .pol_o(pol), .trig_o(trig), .dual_o(dual), .mask_o(mask),
    .edge_set_o(eset), .edge_clr_o(eclr), .route_o(route), .ctx_o(ctx)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    eic_src_cell u_cell (
      .clk(clk), .rst_n(rst_s), .raw_i(src_i[i]), .pol_i(pol[i]),
      .trig_i(trig[i]), .dual_i(dual[i]), .sw_set_i(eset[i]),
      .sw_clr_i(eclr[i]), .pend_o(pend[i])
    );
  end

  assign active = pend & mask;

  eic_route #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .NUM_PIN(NUM_PIN)) u_route (
    .clk(clk), .rst_n(rst_s), .active_i(active), .route_i(route), .ctx_i(ctx),
    .irq_o(irq_o), .nmi_o(nmi_o), .spec_o(spec_o)
  );
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  import eic_pkg::*;
  localparam int NS = 32;
  localparam int NC = 2;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] src = '1;
  logic we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC*NP-1:0] irq;
  logic [NC-1:0] nmi, spec;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_pin[NS];
  bit m_pen[NS];
  bit m_nmi[NS];
  bit m_spe[NS];
  bit [NC-1:0] m_ctx[NS];

  always #5 clk = ~clk;

  ext_irq_ctrl #(.NUM_SRC(NS), .NUM_CTX(NC), .NUM_PIN(NP)) u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .nmi_o(nmi), .spec_o(spec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [NC*NP-1:0] exp_irq(input logic [NS-1:0] act);
    logic [NC*NP-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      for (int c = 0; c < NC; c++)
        if (act[i] && m_pen[i] && m_pin[i] < NP && m_ctx[i][c]) r[c*NP+m_pin[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [NC-1:0] exp_nmi(input logic [NS-1:0] act);
    logic [NC-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      if (act[i] && m_nmi[i]) r = r | m_ctx[i];
    return r;
  endfunction

  function automatic logic [NC-1:0] exp_spec(input logic [NS-1:0] act);
    logic [NC-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      if (act[i] && m_spe[i]) r = r | m_ctx[i];
    return r;
  endfunction

  task automatic route_set(input int i, input logic [31:0] w);
    wr(A_ROUTE + ADDR_W'(i), w);
    m_pen[i] = w[31]; m_nmi[i] = w[30]; m_spe[i] = w[29]; m_pin[i] = int'(w[5:0]);
  endtask

  task automatic ctx_set(input int i, input logic [NC-1:0] m);
    wr(A_CTX + ADDR_W'(i*CTX_STRIDE), 32'(m));
    m_ctx[i] = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [NS-1:0] b;
    for (int i = 0; i < NS; i++) begin
      m_pin[i] = 0; m_pen[i] = 0; m_nmi[i] = 0; m_spe[i] = 0; m_ctx[i] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1: reset state
    rd(A_POL, v);   chk("R1 polarity", v, 0);
    rd(A_TRIG, v);  chk("R1 trigger", v, 0);
    rd(A_DUAL, v);  chk("R1 dual", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 0);
    rd(A_PEND, v);  chk("R1 pending", v, 0);
    rd(A_ROUTE + 10'd7, v); chk("R1 route", v, 0);
    rd(A_CTX + 10'd28, v);  chk("R1 ctx", v, 0);
    chk("R1 outputs", {22'd0, spec, nmi, irq}, 0);

    for (int i = 0; i < NS; i++) begin
      route_set(i, 32'h8000_0000 | 32'(i % NP));
      ctx_set(i, NC'(1 << (i % NC)));
    end

    for (int i = 0; i < NS; i++) begin
      b = NS'(1) << i;
      // R2 level, active-low, mask off
      src[i] = 1'b0; settle();
      rd(A_PEND, v); chk("R2 active-low pending", v, b);
      chk("R9 masked source quiet", 32'(irq), 0);
      wr(A_MSET, b); settle();
      rd(A_MASK, v); chk("R5 set mask", v, b);
      chk("R9 routed irq", 32'(irq), 32'(exp_irq(b)));
      chk("R9 no nmi", 32'(nmi), 0);
      src[i] = 1'b1; settle();
      rd(A_PEND, v); chk("R2 inactive high", v, 0);
      chk("R9 irq drops", 32'(irq), 0);
      // R2 active-high
      wr(A_POL, b); settle();
      rd(A_POL, v); chk("R10 polarity readback", v, b);
      rd(A_PEND, v); chk("R2 active-high pending", v, b);
      src[i] = 1'b0; settle();
      rd(A_PEND, v); chk("R2 active-high low input", v, 0);
      // R3 rising edge
      wr(A_TRIG, b); wr(A_EDGE, 32'(i)); settle();
      rd(A_PEND, v); chk("R3 edge idle", v, 0);
      src[i] = 1'b1; settle();
      rd(A_PEND, v); chk("R3 rising captured", v, b);
      src[i] = 1'b0; settle();
      rd(A_PEND, v); chk("R3 latched after release", v, b);
      chk("R9 edge irq", 32'(irq), 32'(exp_irq(b)));
      wr(A_EDGE, 32'(i)); settle();
      rd(A_PEND, v); chk("R6 edge clear", v, 0);
      // R3 falling edge
      wr(A_POL, 32'h0);
      src[i] = 1'b1; settle();
      rd(A_PEND, v); chk("R3 rise ignored when falling", v, 0);
      src[i] = 1'b0; settle();
      rd(A_PEND, v); chk("R3 falling captured", v, b);
      wr(A_EDGE, 32'(i)); settle();
      // R4 dual edge
      wr(A_DUAL, b);
      src[i] = 1'b1; settle();
      rd(A_PEND, v); chk("R4 dual rising", v, b);
      wr(A_EDGE, 32'(i)); settle();
      rd(A_PEND, v); chk("R4 cleared", v, 0);
      src[i] = 1'b0; settle();
      rd(A_PEND, v); chk("R4 dual falling", v, b);
      src[i] = 1'b1; settle();
      wr(A_EDGE, 32'(i)); wr(A_DUAL, 32'h0); wr(A_TRIG, 32'h0); settle();
      rd(A_PEND, v); chk("R2 back to level idle", v, 0);
      // R6 software set and out-of-range number
      wr(A_TRIG, b); wr(A_EDGE, 32'h8000_0000 | 32'(i)); settle();
      rd(A_PEND, v); chk("R6 software set", v, b);
      wr(A_EDGE, 32'(i)); wr(A_EDGE, 32'h8000_0000 | 32'(i + 64)); settle();
      rd(A_PEND, v); chk("R6 out-of-range ignored", v, 0);
      wr(A_TRIG, 32'h0);
      // R5 zero write, then clear
      wr(A_MSET, 32'h0);
      rd(A_MASK, v); chk("R5 zero write no effect", v, b);
      wr(A_MCLR, 32'h0);
      rd(A_MASK, v); chk("R5 zero clear no effect", v, b);
      wr(A_MCLR, b);
      rd(A_MASK, v); chk("R5 clear mask", v, 0);
    end

    // R7/R8: NMI, special, bad pin, target bitmap
    b = NS'(1) << 3;
    wr(A_MSET, b);
    route_set(3, 32'h4000_0000); ctx_set(3, 2'b11);
    src[3] = 1'b0; settle();
    chk("R7 nmi both contexts", 32'(nmi), 32'(exp_nmi(b)));
    chk("R7 nmi no irq", 32'(irq), 0);
    chk("R7 nmi no spec", 32'(spec), 0);
    route_set(3, 32'h2000_0000); settle();
    chk("R7 special line", 32'(spec), 32'(exp_spec(b)));
    chk("R7 special no nmi", 32'(nmi), 0);
    route_set(3, 32'h8000_0007); settle();
    chk("R7 pin out of range", 32'(irq), 0);
    route_set(3, 32'h8000_0002); ctx_set(3, 2'b10); settle();
    chk("R8 context 1 only", 32'(irq), 32'(exp_irq(b)));
    chk("R8 expected bit 6", 32'(irq), 32'h40);
    ctx_set(3, 2'b00); settle();
    chk("R8 no target", 32'(irq), 0);
    route_set(3, 32'hFFFF_FFFF);
    rd(A_ROUTE + 10'd3, v); chk("R7 route readback", v, 32'hE000_003F);
    wr(A_CTX + 10'd12, 32'hFFFF_FFFF); m_ctx[3] = 2'b11;
    rd(A_CTX + 10'd12, v); chk("R8 ctx readback", v, 32'h3);
    src[3] = 1'b1; wr(A_MCLR, b); settle();

    // R10 write-only words
    rd(A_MSET, v); chk("R10 set-mask reads 0", v, 0);
    rd(A_MCLR, v); chk("R10 clear-mask reads 0", v, 0);
    rd(A_EDGE, v); chk("R10 edge word reads 0", v, 0);
    wr(A_TRIG, 32'hA5A5_0F0F); rd(A_TRIG, v); chk("R10 trigger readback", v, 32'hA5A5_0F0F);
    wr(A_TRIG, 32'h0);
    wr(A_DUAL, 32'h1234_5678); rd(A_DUAL, v); chk("R10 dual readback", v, 32'h1234_5678);
    wr(A_DUAL, 32'h0);

    // R11 latency
    b = NS'(1) << 9;
    wr(A_MSET, b);
    addr = A_PEND;
    @(negedge clk); src[9] = 1'b0;
    @(negedge clk); #1 chk("R11 one edge not yet", rdata, 0);
    @(negedge clk); #1 chk("R11 two edges pending", rdata, 32'(b));
    chk("R11 output not yet", 32'(irq), 0);
    @(negedge clk); #1 chk("R11 output after third", 32'(irq), 32'(exp_irq(b)));
    src[9] = 1'b1; wr(A_MCLR, b); settle();
    chk("R9 all quiet at end", {22'd0, spec, nmi, irq}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule